// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter Unit

This block holds two timer/counter channels, numbered 0 and 1. Each channel is a pair of 8-bit bytes, a low byte and a high byte. A shared mode register and a shared control register set how the channels run. A free-running prescaler divides the input clock into machine-cycle strobes. On each strobe a running channel either advances by one, which is timer operation, or advances when it sees a falling edge on its count input, which is counter operation. An optional gate makes counting depend on the level of an external pin.

Each channel can run in one of four layouts:
- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself;
- a split or stopped layout, in which channel 0 becomes two independent 8-bit counters and channel 1 freezes.

When a count wraps, the channel's overflow flag is set. Software reads and writes all registers through a byte-wide port with separate read and write addresses. The flags also appear as output pins so that an interrupt controller can use them.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, all four counter bytes, the mode register, the control register and both flag outputs read zero.
- R2: Register addresses are fixed as follows: 0 is mode, 1 is control, 2 is channel 0 low, 3 is channel 0 high, 4 is channel 1 low and 5 is channel 1 high. Addresses 6 and 7 read zero. In the mode register, channel i uses bits 4i+3 (gate enable), 4i+2 (count external edges when 1) and 4i+1:4i (layout: 0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split/stop). In the control register, bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Control bits 3:0 read zero.
- R3: In timer operation with its run bit set, a channel advances exactly once per machine cycle. A machine cycle is DIV_RATIO input clocks.
- R4: In counter operation, a channel advances once for each falling edge of its count input. The input is sampled on machine-cycle strobes, so an edge counts when one strobe samples 1 and the next strobe samples 0.
- R5: When the gate enable bit is set, a channel advances only while its gate pin is high. A gated-off channel keeps both of its bytes.
- R6: In the 13-bit layout, the low LOW_FIELD_W bits of the low byte carry into the high byte. Every advance clears the upper bits of the low byte. Going from all ones to zero sets the channel's flag.
- R7: In the 16-bit layout, the high and low bytes form one counter. Going from 0xFFFF to 0 sets the channel's flag.
- R8: In the reload layout, only the low byte counts. When it advances from 0xFF, it takes the high byte's value and sets the channel's flag.
- R9: In the split layout, channel 1 stays frozen. Channel 0's low byte counts under run 0 and the gate rules and sets flag 0. Channel 0's high byte counts machine cycles under run 1 and sets flag 1.
- R10: A write to a counter byte beats an advance in the same cycle; in the split layout this applies to the written byte only. A write to the control register beats a flag set in the same cycle.
- R11: The flag output pins always equal control bits 7 and 5, as {flag 1, flag 0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| cnt_in | input | 2 | External count inputs, bit i for channel i |
| gate_in | input | 2 | Gate pins, bit i for channel i |
| ovf_flag | output | 2 | Overflow flags {flag 1, flag 0} |

## Verification
The bench builds the block with DIV_RATIO = 3 and LOW_FIELD_W = 5. With a three-clock machine cycle, any window of 3, 6 or 9 clocks holds an exact number of strobes, whatever the prescaler phase. This makes hand-computed counts exact. It also lets count-input levels that are held across two strobes be detected quickly. The overflows of the 13-bit and 16-bit layouts are reached by preloading bytes close to the wrap point. A behavioural model checks every register and both flags on every cycle, including the cases where writes and overflows collide.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

   localparam int DATA_W = 8;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      LAYOUT_13     = 2'd0,
      LAYOUT_16     = 2'd1,
      LAYOUT_RELOAD = 2'd2,
      LAYOUT_SPLIT  = 2'd3
   } layout_e;

   localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
   localparam logic [ADDR_W-1:0] A_CH0L = 3'd2;

   // bit offsets inside one 4-bit channel field of the mode register
   localparam int F_GATE = 3;
   localparam int F_EXT  = 2;

   // control register bit positions for channel i: run at RUN_B+2i, flag at FLAG_B+2i
   localparam int RUN_B  = 4;
   localparam int FLAG_B = 5;

endpackage

// File: rtl/dtu_prescaler.sv
module dtu_prescaler #(
   parameter int DIV_RATIO = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/dtu_edge_sampler.sv
module dtu_edge_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic fall
);
   logic prev_q;

   assign fall = tick & prev_q & ~pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b0;
      else if (tick) prev_q <= pin;
   end
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
   import dtu_pkg::*;
#(
   parameter int LOW_FIELD_W = 5,
   parameter bit SPLIT_OK    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  layout_e           layout,
   input  logic              inc_main,
   input  logic              inc_aux,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lo_q,
   output logic [DATA_W-1:0] hi_q,
   output logic              ovf_main,
   output logic              ovf_aux
);
   localparam int NARROW_W = LOW_FIELD_W + DATA_W;
   localparam int WIDE_W   = 2 * DATA_W;

   logic [NARROW_W:0]   sum_n;
   logic [WIDE_W:0]     sum_w;
   logic [DATA_W-1:0]   lo_d, hi_d;
   logic [DATA_W-1:0]   sp_lo, sp_hi;
   logic                sp_lo_ovf, sp_hi_ovf;
   logic                wr_any;

   assign wr_any = wr_lo | wr_hi;
   assign sum_n  = {1'b0, hi_q, lo_q[LOW_FIELD_W-1:0]} + {{NARROW_W{1'b0}}, 1'b1};
   assign sum_w  = {1'b0, hi_q, lo_q} + {{WIDE_W{1'b0}}, 1'b1};

   generate
      if (SPLIT_OK) begin : g_split
         assign sp_lo     = lo_q + {{(DATA_W-1){1'b0}}, 1'b1};
         assign sp_hi     = hi_q + {{(DATA_W-1){1'b0}}, 1'b1};
         assign sp_lo_ovf = &lo_q;
         assign sp_hi_ovf = &hi_q;
      end else begin : g_stop
         assign sp_lo     = lo_q;
         assign sp_hi     = hi_q;
         assign sp_lo_ovf = 1'b0;
         assign sp_hi_ovf = 1'b0;
      end
   endgenerate

   always_comb begin
      lo_d     = lo_q;
      hi_d     = hi_q;
      ovf_main = 1'b0;
      ovf_aux  = 1'b0;
      unique case (layout)
         LAYOUT_13: if (inc_main && !wr_any) begin
            lo_d     = {{(DATA_W-LOW_FIELD_W){1'b0}}, sum_n[LOW_FIELD_W-1:0]};
            hi_d     = sum_n[NARROW_W-1:LOW_FIELD_W];
            ovf_main = sum_n[NARROW_W];
         end
         LAYOUT_16: if (inc_main && !wr_any) begin
            lo_d     = sum_w[DATA_W-1:0];
            hi_d     = sum_w[WIDE_W-1:DATA_W];
            ovf_main = sum_w[WIDE_W];
         end
         LAYOUT_RELOAD: if (inc_main && !wr_any) begin
            if (&lo_q) begin
               lo_d     = hi_q;
               ovf_main = 1'b1;
            end else begin
               lo_d = lo_q + {{(DATA_W-1){1'b0}}, 1'b1};
            end
         end
         LAYOUT_SPLIT: begin
            if (inc_main && !wr_lo) begin
               lo_d     = sp_lo;
               ovf_main = sp_lo_ovf;
            end
            if (inc_aux && !wr_hi) begin
               hi_d    = sp_hi;
               ovf_aux = sp_hi_ovf;
            end
         end
         default: ;
      endcase
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
   import dtu_pkg::*;
#(
   parameter int DIV_RATIO   = 12,
   parameter int LOW_FIELD_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic [1:0] cnt_in,
   input  logic [1:0] gate_in,
   output logic [1:0] ovf_flag
);
   localparam int NCH = 2;

   generate
      if (DIV_RATIO < 2) begin : g_bad_div
         $error("DIV_RATIO must be at least 2");
      end
      if (LOW_FIELD_W < 1 || LOW_FIELD_W > DATA_W - 1) begin : g_bad_field
         $error("LOW_FIELD_W must lie in 1..DATA_W-1");
      end
   endgenerate

   logic                      tick;
   logic [DATA_W-1:0]         mode_q;
   logic [NCH-1:0]            run_q, tf_q, tf_set;
   logic [NCH-1:0]            fall, inc, aux, ovf_main, ovf_aux;
   logic [NCH-1:0][DATA_W-1:0] lo_q, hi_q;
   logic                      wr_mode, wr_ctrl;

   assign wr_mode = wr_en && (wr_addr == A_MODE);
   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

   dtu_prescaler #(.DIV_RATIO(DIV_RATIO)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_LO = A_CH0L + ADDR_W'(2 * i);
         localparam logic [ADDR_W-1:0] A_HI = A_CH0L + ADDR_W'(2 * i + 1);

         logic [3:0] fld;
         logic       en;
         logic       w_lo, w_hi;

         assign fld  = mode_q[4*i +: 4];
         assign en   = run_q[i] & (~fld[F_GATE] | gate_in[i]);
         assign inc[i] = en & (fld[F_EXT] ? fall[i] : tick);
         assign aux[i] = (i == 0) ? (tick & run_q[NCH-1]) : 1'b0;
         assign w_lo = wr_en && (wr_addr == A_LO);
         assign w_hi = wr_en && (wr_addr == A_HI);

         dtu_edge_sampler u_samp (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .pin(cnt_in[i]), .fall(fall[i])
         );

         dtu_channel #(
            .LOW_FIELD_W(LOW_FIELD_W),
            .SPLIT_OK   (i == 0)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .layout  (layout_e'(fld[1:0])),
            .inc_main(inc[i]),
            .inc_aux (aux[i]),
            .wr_lo   (w_lo),
            .wr_hi   (w_hi),
            .wdata   (wr_data),
            .lo_q    (lo_q[i]),
            .hi_q    (hi_q[i]),
            .ovf_main(ovf_main[i]),
            .ovf_aux (ovf_aux[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q[i] <= 1'b0;
               tf_q[i]  <= 1'b0;
            end else if (wr_ctrl) begin
               run_q[i] <= wr_data[RUN_B + 2*i];
               tf_q[i]  <= wr_data[FLAG_B + 2*i];
            end else begin
               tf_q[i]  <= tf_q[i] | tf_set[i];
            end
         end
      end
   endgenerate

   // split high byte of channel 0 reports through flag 1
   assign tf_set[0] = ovf_main[0];
   assign tf_set[1] = ovf_main[1] | ovf_aux[0] | ovf_aux[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= wr_data;
   end

   always_comb begin
      unique case (rd_addr)
         3'd0:    rd_data = mode_q;
         3'd1:    rd_data = {tf_q[1], run_q[1], tf_q[0], run_q[0], 4'b0000};
         3'd2:    rd_data = lo_q[0];
         3'd3:    rd_data = hi_q[0];
         3'd4:    rd_data = lo_q[1];
         3'd5:    rd_data = hi_q[1];
         default: rd_data = '0;
      endcase
   end

   assign ovf_flag = tf_q;
endmodule

// File: rtl/dual_timer_unit_chk.sv
module dual_timer_unit_chk (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            wr_en,
   input logic [2:0]      wr_addr,
   input logic [7:0]      wr_data,
   input logic [7:0]      mode_q,
   input logic [1:0][7:0] lo_q,
   input logic [1:0][7:0] hi_q,
   input logic [1:0]      tf_q,
   input logic [1:0]      gate_in
);
   // R3
   lo0_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lo_q[0] != $past(lo_q[0])) && !$past(wr_en)) |-> $past(tick));

   // R5
   gated_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[3] && !gate_in[0] && (mode_q[1:0] != 2'd3) &&
       !(wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3)))
      |=> ($stable(lo_q[0]) && $stable(hi_q[0])));

   // R9
   ch1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[5:4] == 2'd3) && !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)))
      |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

   // R10
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd2) |=> (lo_q[0] == $past(wr_data)));

   // R10
   flag_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd1 && !wr_data[5]) |=> !tf_q[0]);

   // R11
   flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tf_q[1]) |-> ($past(tick) || $past(wr_en && wr_addr == 3'd1)));
endmodule

bind dual_timer_unit dual_timer_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q),
   .tf_q(tf_q), .gate_in(gate_in)
);

// File: tb/dual_timer_unit_bench.sv
`timescale 1ns/100ps
module dual_timer_unit_bench;
   localparam int DIV = 3;
   localparam int LFW = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [1:0] cnt_in = '0;
   logic [1:0] gate_in = '0;
   logic [1:0] ovf_flag;

   int checks = 0, failures = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   dual_timer_unit #(.DIV_RATIO(DIV), .LOW_FIELD_W(LFW)) u_dual_timer_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cnt_in(cnt_in), .gate_in(gate_in),
      .ovf_flag(ovf_flag)
   );

   // behavioural reference model
   int m_lo[2], m_hi[2], m_mode, m_run[2], m_tf[2], m_pc, m_prev[2];

   function automatic int model_rd(input int a);
      case (a)
         0: return m_mode;
         1: return m_tf[1]*128 + m_run[1]*64 + m_tf[0]*32 + m_run[0]*16;
         2: return m_lo[0];
         3: return m_hi[0];
         4: return m_lo[1];
         5: return m_hi[1];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_run[c] = 0; m_tf[c] = 0; m_prev[c] = 0;
         end
         m_mode = 0; m_pc = 0;
      end else begin
         int nlo[2], nhi[2], setf[2], incs[2], wl[2], wh[2];
         int tk, fld, lay, v;
         tk = (m_pc == DIV - 1);
         setf[0] = 0; setf[1] = 0;
         for (int c = 0; c < 2; c++) begin
            fld = (m_mode >> (4*c)) & 15;
            wl[c] = wr_en && (wr_addr == 2 + 2*c);
            wh[c] = wr_en && (wr_addr == 3 + 2*c);
            incs[c] = m_run[c] && (!(fld & 8) || gate_in[c]) &&
                      ((fld & 4) ? (tk && m_prev[c] && !cnt_in[c]) : tk);
            nlo[c] = m_lo[c]; nhi[c] = m_hi[c];
         end
         for (int c = 0; c < 2; c++) begin
            lay = (m_mode >> (4*c)) & 3;
            if (lay == 0 && incs[c] && !(wl[c] || wh[c])) begin
               v = m_hi[c] * (1 << LFW) + (m_lo[c] % (1 << LFW)) + 1;
               if (v == 256 * (1 << LFW)) begin v = 0; setf[c] = 1; end
               nlo[c] = v % (1 << LFW); nhi[c] = v / (1 << LFW);
            end else if (lay == 1 && incs[c] && !(wl[c] || wh[c])) begin
               v = m_hi[c] * 256 + m_lo[c] + 1;
               if (v == 65536) begin v = 0; setf[c] = 1; end
               nlo[c] = v % 256; nhi[c] = v / 256;
            end else if (lay == 2 && incs[c] && !(wl[c] || wh[c])) begin
               if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; setf[c] = 1; end
               else nlo[c] = m_lo[c] + 1;
            end else if (lay == 3 && c == 0) begin
               if (incs[0] && !wl[0]) begin
                  nlo[0] = (m_lo[0] + 1) % 256;
                  if (m_lo[0] == 255) setf[0] = 1;
               end
               if (tk && m_run[1] && !wh[0]) begin
                  nhi[0] = (m_hi[0] + 1) % 256;
                  if (m_hi[0] == 255) setf[1] = 1;
               end
            end
            if (wl[c]) nlo[c] = wr_data;
            if (wh[c]) nhi[c] = wr_data;
         end
         for (int c = 0; c < 2; c++) begin
            m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
            if (wr_en && wr_addr == 1) begin
               m_run[c] = wr_data[4 + 2*c]; m_tf[c] = wr_data[5 + 2*c];
            end else if (setf[c]) m_tf[c] = 1;
            if (tk) m_prev[c] = cnt_in[c];
         end
         if (wr_en && wr_addr == 0) m_mode = wr_data;
         m_pc = tk ? 0 : m_pc + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // continuous comparison against the model, late in each low phase
   always @(negedge clk) begin
      #1.5;
      if (rst_n && !done) begin
         check(rd_data == 8'(model_rd(rd_addr)), cur_req, rd_data, model_rd(rd_addr));
         check(ovf_flag == {1'(m_tf[1]), 1'(m_tf[0])}, "R11", ovf_flag,
               m_tf[1]*2 + m_tf[0]);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, input int exp, input string req);
      rd_addr = a;
      #0.1;
      check(rd_data == 8'(exp), req, rd_data, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      cur_req = "R1";
      for (int a = 0; a < 6; a++) peek(3'(a), 0, "R1");
      check(ovf_flag == 2'b00, "R1", ovf_flag, 0);
      idle(1);

      // R2 register map
      cur_req = "R2";
      wr(3'd0, 8'hA5);
      peek(3'd0, 8'hA5, "R2");
      wr(3'd1, 8'hFF);
      peek(3'd1, 8'hF0, "R2");
      peek(3'd6, 0, "R2");
      peek(3'd7, 0, "R2");
      idle(1);

      // R3 timer operation
      cur_req = "R3";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h11);
      wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
      wr(3'd1, 8'h10);
      idle(30);
      peek(3'd2, 10, "R3");
      peek(3'd3, 0, "R3");
      peek(3'd4, 0, "R3");
      idle(1);

      // R4 counter operation
      cur_req = "R4";
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd0, 8'h05);
      wr(3'd1, 8'h10);
      for (int k = 0; k < 5; k++) begin
         cnt_in[0] = 1'b1; idle(2*DIV);
         cnt_in[0] = 1'b0; idle(2*DIV);
      end
      peek(3'd2, 5, "R4");
      idle(1);

      // R5 gating
      cur_req = "R5";
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h09);
      gate_in[0] = 1'b0;
      wr(3'd1, 8'h10);
      idle(30);
      peek(3'd2, 0, "R5");
      gate_in[0] = 1'b1;
      idle(30);
      peek(3'd2, 10, "R5");
      gate_in[0] = 1'b0;
      idle(1);

      // R6 13-bit layout
      cur_req = "R6";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'hE3); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      idle(DIV);
      peek(3'd2, 8'h04, "R6");
      peek(3'd3, 8'h00, "R6");
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h1E); wr(3'd3, 8'hFF);
      wr(3'd1, 8'h10);
      idle(2*DIV);
      peek(3'd2, 8'h00, "R6");
      peek(3'd3, 8'h00, "R6");
      peek(3'd1, 8'h30, "R6");
      check(ovf_flag == 2'b01, "R11", ovf_flag, 1);
      idle(1);

      // R7 16-bit layout
      cur_req = "R7";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
      wr(3'd1, 8'h10);
      idle(2*DIV);
      peek(3'd2, 8'h00, "R7");
      peek(3'd3, 8'h00, "R7");
      peek(3'd1, 8'h30, "R7");
      idle(1);

      // R8 reload layout
      cur_req = "R8";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h02);
      wr(3'd3, 8'hA0); wr(3'd2, 8'hFE);
      wr(3'd1, 8'h10);
      idle(3*DIV);
      peek(3'd2, 8'hA1, "R8");
      peek(3'd3, 8'hA0, "R8");
      peek(3'd1, 8'h30, "R8");
      idle(1);

      // R9 split layout
      cur_req = "R9";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h33);
      wr(3'd4, 8'h55); wr(3'd5, 8'h66);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
      wr(3'd1, 8'h50);
      idle(3*DIV);
      peek(3'd2, 8'h01, "R9");
      peek(3'd3, 8'h00, "R9");
      peek(3'd4, 8'h55, "R9");
      peek(3'd5, 8'h66, "R9");
      peek(3'd1, 8'hF0, "R9");
      check(ovf_flag == 2'b11, "R11", ovf_flag, 3);
      idle(1);

      // R10 write beats advance
      cur_req = "R10";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      for (int k = 0; k < 2*DIV; k++) wr(3'd2, 8'h77);
      peek(3'd2, 8'h77, "R10");
      peek(3'd3, 8'h00, "R10");
      idle(20);

      finish_run();
   end
endmodule